// File: doc/BRIEF.md
# ECC Error Capture and Injection Unit

This unit sits beside a 64-bit ECC memory datapath. It does not compute the code. On each checked read, the ECC checker hands it a valid strobe, two flags (corrected and uncorrectable), the raw 64-bit data, the 8-bit check code and the memory address. The unit records the first reported failure in capture registers and keeps sticky status bits. Corrected errors are counted against a programmable threshold before they are reported. An interrupt line is raised for each enabled status bit that is set.

On the write side, the unit combines outgoing data and check code with software-programmed flip masks. Software can use this to plant known faults in memory. All state is reached through a simple 32-bit word-addressed register bus. Writes commit on the clock edge and reads are combinational from the address.

Top module: `ecc_err_monitor`

## Requirements
- R1: After reset the following all read as zero: status, interrupt enables, suppress bits, the single-bit count and every injection register, and `irq` is low. The threshold field reads 1, so the single-bit control register reads 0x00010000.
- R2: Status register (word 0) bit 1 is the multi-bit flag and bit 0 is the single-bit flag. A reported event sets its bit at the next clock edge, and the bit stays set until software clears it.
- R3: Writing word 0 clears each status bit whose write-data bit is 1 and leaves the others unchanged. If an event and a clear hit the same bit in the same cycle, the event wins.
- R4: `irq` is high exactly while a status bit is set and its enable in word 1 is set. Bit 0 of word 1 enables single-bit interrupts and bit 1 enables multi-bit interrupts.
- R5: A reported event that finds no status bit pending latches the following: data[63:32] into word 4, data[31:0] into word 5, the check code into word 6 bits 7:0, address[31:0] into word 7, and the upper address bits into the low bits of word 8.
- R6: While any status bit is pending, later events leave the capture registers unchanged.
- R7: Word 3 holds the threshold in bits 23:16 and the read-only single-bit count in bits 7:0. Each corrected event increments the count. When the incremented value reaches the threshold, the single-bit flag is set and the count returns to 0. A threshold of 0 behaves like 1.
- R8: Word 2 bit 0 suppresses single-bit events and bit 1 suppresses multi-bit events. A suppressed event changes neither status, count nor capture. A strobe that carries both flags is treated as multi-bit only.
- R9: When word 11 bit 8 is set, write data leaves XORed with {word 9, word 10} and the write check code leaves XORed with word 11 bits 7:0. When bit 8 is clear, both pass through unchanged.
- R10: Words 1, 2, 3 (threshold field), 9, 10 and 11 read back what was written. Undecoded words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| chk_valid | input | 1 | Checker result valid this cycle |
| chk_sbe | input | 1 | Corrected (single-bit) error flag |
| chk_mbe | input | 1 | Uncorrectable (multi-bit) error flag |
| chk_data | input | 64 | Raw data of the checked word |
| chk_code | input | 8 | Raw check code of the checked word |
| chk_addr | input | 36 | Address of the checked word |
| wr_data_in | input | 64 | Outgoing write data before injection |
| wr_code_in | input | 8 | Outgoing check code before injection |
| wr_data_out | output | 64 | Write data after injection |
| wr_code_out | output | 8 | Check code after injection |
| irq | output | 1 | Error interrupt |

## Verification
Status, count and capture results are registered, so they become visible one clock edge after the cycle in which the event or bus write is driven. `irq`, read data and the injection outputs follow that state or their inputs combinationally in the same cycle. The bench drives stimulus on falling edges and lets exactly one rising edge pass. It then samples one time unit after the next falling edge, which is when registered results are due. Combinational results are sampled one time unit after their inputs change.

// File: rtl/ecc_err_pkg.sv
// Shared constants for the ECC error capture unit: register word map
// and status bit positions. Assumes a 4-bit word-address bus.
package ecc_err_pkg;
    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] A_STATUS   = 4'd0;
    localparam logic [REG_AW-1:0] A_IRQ_EN   = 4'd1;
    localparam logic [REG_AW-1:0] A_SUPPRESS = 4'd2;
    localparam logic [REG_AW-1:0] A_SBE_CTL  = 4'd3;
    localparam logic [REG_AW-1:0] A_CAP_DHI  = 4'd4;
    localparam logic [REG_AW-1:0] A_CAP_DLO  = 4'd5;
    localparam logic [REG_AW-1:0] A_CAP_CODE = 4'd6;
    localparam logic [REG_AW-1:0] A_CAP_ALO  = 4'd7;
    localparam logic [REG_AW-1:0] A_CAP_AHI  = 4'd8;
    localparam logic [REG_AW-1:0] A_INJ_DHI  = 4'd9;
    localparam logic [REG_AW-1:0] A_INJ_DLO  = 4'd10;
    localparam logic [REG_AW-1:0] A_INJ_CTL  = 4'd11;

    localparam int ST_SINGLE = 0;
    localparam int ST_MULTI  = 1;
    localparam int THR_LSB   = 16;
endpackage

// File: rtl/ecc_sbe_counter.sv
// Single-bit error counter. Counts corrected events and pulses 'report'
// when the incremented count reaches the threshold, then restarts at 0.
// Assumes: a threshold of 0 is treated like 1.
module ecc_sbe_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sbe_evt,
    input  logic [CNT_W-1:0] thr,
    output logic             report,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W:0] cnt_inc;

    // Next count value and the threshold hit decision.
    always_comb begin
        cnt_inc = (CNT_W+1)'(count) + (CNT_W+1)'(1);
        report  = sbe_evt && ((thr == '0) || (cnt_inc >= {1'b0, thr}));
    end

    // Count register: advance on events, restart on a report.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (report)  count <= '0;
        else if (sbe_evt) count <= cnt_inc[CNT_W-1:0];
    end
endmodule

// File: rtl/ecc_err_capture.sv
// Sticky status bits plus first-failure capture. Set beats clear in the
// same cycle. Capture loads only when nothing is pending.
module ecc_err_capture #(
    parameter int DATA_W  = 64,
    parameter int CODE_W  = 8,
    parameter int MADDR_W = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         set_vec,
    input  logic [1:0]         clr_vec,
    input  logic [DATA_W-1:0]  data,
    input  logic [CODE_W-1:0]  code,
    input  logic [MADDR_W-1:0] addr,
    output logic [1:0]         status,
    output logic [DATA_W-1:0]  cap_data,
    output logic [CODE_W-1:0]  cap_code,
    output logic [MADDR_W-1:0] cap_addr
);
    logic load;

    // Capture only the first reported failure.
    assign load = (|set_vec) && (status == 2'b00);

    // Status: write-one-to-clear, with new events taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= 2'b00;
        else        status <= (status & ~clr_vec) | set_vec;
    end

    // Capture registers for data, check code and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_data <= '0;
            cap_code <= '0;
            cap_addr <= '0;
        end else if (load) begin
            cap_data <= data;
            cap_code <= code;
            cap_addr <= addr;
        end
    end
endmodule

// File: rtl/ecc_inject.sv
// Write-path fault injection: XORs the programmed masks into the data and
// check code when enabled. Purely combinational.
module ecc_inject #(
    parameter int DATA_W = 64,
    parameter int CODE_W = 8
) (
    input  logic              en,
    input  logic [DATA_W-1:0] data_mask,
    input  logic [CODE_W-1:0] code_mask,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CODE_W-1:0] code_in,
    output logic [DATA_W-1:0] data_out,
    output logic [CODE_W-1:0] code_out
);
    // Apply the masks only when injection is armed.
    always_comb begin
        data_out = data_in ^ (en ? data_mask : '0);
        code_out = code_in ^ (en ? code_mask : '0);
    end
endmodule

// File: rtl/ecc_err_monitor.sv
// ECC error capture and injection unit, top level. Decodes the register
// bus, qualifies checker events, and combines the counter, capture and
// injection blocks. Assumes WORD_W >= 24 and WORD_W < MADDR_W <= 2*WORD_W.
module ecc_err_monitor
    import ecc_err_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int CODE_W  = 8,
    parameter int CNT_W   = 8,
    parameter int MADDR_W = 36
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic                 chk_valid,
    input  logic                 chk_sbe,
    input  logic                 chk_mbe,
    input  logic [2*WORD_W-1:0]  chk_data,
    input  logic [CODE_W-1:0]    chk_code,
    input  logic [MADDR_W-1:0]   chk_addr,
    input  logic [2*WORD_W-1:0]  wr_data_in,
    input  logic [CODE_W-1:0]    wr_code_in,
    output logic [2*WORD_W-1:0]  wr_data_out,
    output logic [CODE_W-1:0]    wr_code_out,
    output logic                 irq
);
    localparam int DATA_W     = 2 * WORD_W;
    localparam int AHI_W      = MADDR_W - WORD_W;
    localparam int INJ_EN_BIT = CODE_W;

    logic [1:0]         irq_en_q, suppress_q, status_q, set_vec, clr_vec;
    logic [CNT_W-1:0]   thr_q, sbe_count;
    logic [WORD_W-1:0]  inj_hi_q, inj_lo_q;
    logic [CODE_W-1:0]  inj_code_q, cap_code;
    logic               inj_en_q, sbe_evt, mbe_evt, sbe_report;
    logic [DATA_W-1:0]  cap_data;
    logic [MADDR_W-1:0] cap_addr;

    // Event qualification: multi-bit wins over single-bit, suppress masks.
    always_comb begin
        mbe_evt = chk_valid && chk_mbe && !suppress_q[ST_MULTI];
        sbe_evt = chk_valid && chk_sbe && !chk_mbe && !suppress_q[ST_SINGLE];
        set_vec = '0;
        set_vec[ST_MULTI]  = mbe_evt;
        set_vec[ST_SINGLE] = sbe_report;
        clr_vec = (reg_wr && reg_addr == A_STATUS) ? reg_wdata[1:0] : 2'b00;
    end

    // Software-writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q   <= '0;
            suppress_q <= '0;
            thr_q      <= CNT_W'(1);
            inj_hi_q   <= '0;
            inj_lo_q   <= '0;
            inj_code_q <= '0;
            inj_en_q   <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_IRQ_EN:   irq_en_q   <= reg_wdata[1:0];
                A_SUPPRESS: suppress_q <= reg_wdata[1:0];
                A_SBE_CTL:  thr_q      <= reg_wdata[THR_LSB +: CNT_W];
                A_INJ_DHI:  inj_hi_q   <= reg_wdata;
                A_INJ_DLO:  inj_lo_q   <= reg_wdata;
                A_INJ_CTL: begin
                    inj_code_q <= reg_wdata[CODE_W-1:0];
                    inj_en_q   <= reg_wdata[INJ_EN_BIT];
                end
                default: ;
            endcase
        end
    end

    ecc_sbe_counter #(.CNT_W(CNT_W)) u_sbe_cnt (
        .clk(clk), .rst_n(rst_n), .sbe_evt(sbe_evt), .thr(thr_q),
        .report(sbe_report), .count(sbe_count)
    );

    ecc_err_capture #(.DATA_W(DATA_W), .CODE_W(CODE_W), .MADDR_W(MADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .data(chk_data), .code(chk_code), .addr(chk_addr),
        .status(status_q), .cap_data(cap_data), .cap_code(cap_code),
        .cap_addr(cap_addr)
    );

    ecc_inject #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_inj (
        .en(inj_en_q), .data_mask({inj_hi_q, inj_lo_q}), .code_mask(inj_code_q),
        .data_in(wr_data_in), .code_in(wr_code_in),
        .data_out(wr_data_out), .code_out(wr_code_out)
    );

    // Interrupt: any enabled status bit.
    assign irq = |(status_q & irq_en_q);

    // Combinational read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATUS:   reg_rdata[1:0] = status_q;
            A_IRQ_EN:   reg_rdata[1:0] = irq_en_q;
            A_SUPPRESS: reg_rdata[1:0] = suppress_q;
            A_SBE_CTL: begin
                reg_rdata[THR_LSB +: CNT_W] = thr_q;
                reg_rdata[CNT_W-1:0]        = sbe_count;
            end
            A_CAP_DHI:  reg_rdata = cap_data[DATA_W-1:WORD_W];
            A_CAP_DLO:  reg_rdata = cap_data[WORD_W-1:0];
            A_CAP_CODE: reg_rdata[CODE_W-1:0] = cap_code;
            A_CAP_ALO:  reg_rdata = cap_addr[WORD_W-1:0];
            A_CAP_AHI:  reg_rdata[AHI_W-1:0] = cap_addr[MADDR_W-1:WORD_W];
            A_INJ_DHI:  reg_rdata = inj_hi_q;
            A_INJ_DLO:  reg_rdata = inj_lo_q;
            A_INJ_CTL: begin
                reg_rdata[CODE_W-1:0]  = inj_code_q;
                reg_rdata[INJ_EN_BIT]  = inj_en_q;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_monitor_checks.sv
// Assertion checker for ecc_err_monitor, attached with bind below.
module ecc_err_monitor_checks #(
    parameter int DATA_W = 64,
    parameter int REG_AW = 4,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chk_valid,
    input logic              chk_mbe,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic              irq,
    input logic [1:0]        status,
    input logic [1:0]        irq_en,
    input logic [1:0]        suppress,
    input logic [DATA_W-1:0] cap_data,
    input logic              inj_en,
    input logic [DATA_W-1:0] wr_data_in,
    input logic [DATA_W-1:0] wr_data_out
);
    logic mbe_live;
    assign mbe_live = chk_valid && chk_mbe && !suppress[1];

    assert_multi_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mbe_live |=> status[1]);

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0 && reg_wdata[1] && !mbe_live) |=> !status[1]);

    assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> !irq);

    assert_cap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b00) |=> $stable(cap_data));

    assert_no_spurious_multi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[1] && !mbe_live) |=> !status[1]);

    assert_inject_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_en |-> (wr_data_out == wr_data_in));
endmodule

bind ecc_err_monitor ecc_err_monitor_checks #(
    .DATA_W(DATA_W), .REG_AW(ecc_err_pkg::REG_AW), .WORD_W(WORD_W)
) u_checks (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_mbe(chk_mbe),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq),
    .status(status_q), .irq_en(irq_en_q), .suppress(suppress_q),
    .cap_data(cap_data), .inj_en(inj_en_q),
    .wr_data_in(wr_data_in), .wr_data_out(wr_data_out)
);

// File: tb/tb_ecc_err_monitor.sv
module tb_ecc_err_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int N_INJ = 4;
    // {en, mask_hi, mask_lo, code_mask, data_in, code_in}
    localparam logic [144:0] INJ_VEC [N_INJ] = '{
        {1'b1, 32'hFFFF0000, 32'h00000001, 8'h00, 64'h0123456789ABCDEF, 8'h5A},
        {1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'hFF, 64'hAAAA5555AAAA5555, 8'h3C},
        {1'b1, 32'h00000000, 32'h00000000, 8'h81, 64'h0000000000000000, 8'h00},
        {1'b1, 32'h80000000, 32'h00000000, 8'h01, 64'hFFFFFFFFFFFFFFFF, 8'hFF}
    };

    logic        clk = 0, rst_n = 0, reg_wr = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        chk_valid = 0, chk_sbe = 0, chk_mbe = 0;
    logic [63:0] chk_data = 0, wr_data_in = 0, wr_data_out;
    logic [7:0]  chk_code = 0, wr_code_in = 0, wr_code_out;
    logic [35:0] chk_addr = 0;
    logic        irq;
    int total = 0, bad = 0, cycles = 0;
    bit  done = 0;
    logic [31:0] rv;

    ecc_err_monitor dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic evt(input logic s, input logic m, input logic [63:0] d,
                       input logic [7:0] c, input logic [35:0] a);
        @(negedge clk); chk_valid = 1; chk_sbe = s; chk_mbe = m;
        chk_data = d; chk_code = c; chk_addr = a;
        @(negedge clk); chk_valid = 0; chk_sbe = 0; chk_mbe = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk); cycles++;
            if (cycles > 20000 && !done) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(4'd0, rv);  check("R1 status", rv, 0);
        rd(4'd3, rv);  check("R1 sbe ctl", rv, 32'h00010000);
        rd(4'd1, rv);  check("R1 irq en", rv, 0);
        rd(4'd11, rv); check("R1 inj ctl", rv, 0);
        check("R1 irq", irq, 0);

        // Injection vector table (R9, R10)
        for (int i = 0; i < N_INJ; i++) begin
            logic [144:0] v = INJ_VEC[i];
            logic [63:0] ed;
            logic [7:0]  ec;
            wr(4'd9, v[143:112]);
            wr(4'd10, v[111:80]);
            wr(4'd11, {23'd0, v[144], v[79:72]});
            rd(4'd9, rv);  check("R10 inj hi readback", rv, v[143:112]);
            rd(4'd11, rv); check("R10 inj ctl readback", rv, {23'd0, v[144], v[79:72]});
            wr_data_in = v[71:8]; wr_code_in = v[7:0]; #1;
            ed = v[144] ? (v[71:8] ^ v[143:80]) : v[71:8];
            ec = v[144] ? (v[7:0] ^ v[79:72]) : v[7:0];
            check("R9 data out", wr_data_out, ed);
            check("R9 code out", wr_code_out, ec);
        end
        wr(4'd11, 0);

        // R2/R5 multi-bit capture
        evt(0, 1, 64'hDEADBEEF_CAFEF00D, 8'hA5, 36'h9_1234_5678);
        rd(4'd0, rv); check("R2 status multi", rv, 2);
        rd(4'd4, rv); check("R5 cap hi", rv, 32'hDEADBEEF);
        rd(4'd5, rv); check("R5 cap lo", rv, 32'hCAFEF00D);
        rd(4'd6, rv); check("R5 cap code", rv, 32'hA5);
        rd(4'd7, rv); check("R5 cap addr lo", rv, 32'h12345678);
        rd(4'd8, rv); check("R5 cap addr hi", rv, 32'h9);
        check("R4 irq masked", irq, 0);
        wr(4'd1, 2); #1; check("R4 irq multi enabled", irq, 1);
        wr(4'd1, 1); #1; check("R4 irq only single enabled", irq, 0);

        // R6 second event keeps capture; R2 single set with threshold 1
        evt(1, 0, 64'h1111_2222_3333_4444, 8'h0F, 36'h0_0000_0040);
        rd(4'd0, rv); check("R2 status both", rv, 3);
        rd(4'd4, rv); check("R6 cap hi held", rv, 32'hDEADBEEF);
        rd(4'd6, rv); check("R6 cap code held", rv, 32'hA5);
        #1; check("R4 irq single", irq, 1);

        // R3 write-one-to-clear
        wr(4'd0, 1); rd(4'd0, rv); check("R3 clear single only", rv, 2);
        wr(4'd0, 0); rd(4'd0, rv); check("R3 zero write keeps", rv, 2);
        // set beats clear in the same cycle
        @(negedge clk); reg_addr = 0; reg_wdata = 2; reg_wr = 1;
        chk_valid = 1; chk_mbe = 1;
        @(negedge clk); reg_wr = 0; chk_valid = 0; chk_mbe = 0;
        rd(4'd0, rv); check("R3 set wins over clear", rv, 2);
        wr(4'd0, 3); rd(4'd0, rv); check("R3 clear all", rv, 0);

        // R5 new capture after clear
        evt(0, 1, 64'h5555_6666_7777_8888, 8'h11, 36'h3_0000_1000);
        rd(4'd4, rv); check("R5 recapture hi", rv, 32'h55556666);
        rd(4'd8, rv); check("R5 recapture addr hi", rv, 32'h3);
        wr(4'd0, 3);

        // R7 threshold counting
        wr(4'd3, 32'h00030000);
        evt(1, 0, 64'h1, 8'h1, 36'h1);
        evt(1, 0, 64'h2, 8'h2, 36'h2);
        rd(4'd0, rv); check("R7 below threshold", rv, 0);
        rd(4'd3, rv); check("R7 count two", rv, 32'h00030002);
        evt(1, 0, 64'h3, 8'h3, 36'h3);
        rd(4'd0, rv); check("R7 threshold reached", rv, 1);
        rd(4'd3, rv); check("R7 count restarts", rv, 32'h00030000);
        rd(4'd5, rv); check("R7 capture on report", rv, 32'h3);
        wr(4'd0, 3);
        wr(4'd3, 0);
        evt(1, 0, 64'h4, 8'h4, 36'h4);
        rd(4'd0, rv); check("R7 zero threshold reports", rv, 1);
        wr(4'd0, 3);

        // R8 suppression
        wr(4'd3, 32'h00030000);
        wr(4'd2, 3);
        rd(4'd2, rv); check("R10 suppress readback", rv, 3);
        evt(1, 0, 64'h7, 8'h7, 36'h7);
        evt(0, 1, 64'h8, 8'h8, 36'h8);
        rd(4'd0, rv); check("R8 suppressed status", rv, 0);
        rd(4'd3, rv); check("R8 suppressed count", rv, 32'h00030000);
        wr(4'd2, 0);
        evt(1, 1, 64'h9, 8'h9, 36'h9);
        rd(4'd0, rv); check("R8 both flags is multi", rv, 2);
        rd(4'd3, rv); check("R8 both flags no count", rv, 32'h00030000);
        wr(4'd0, 3);
        evt(1, 0, 64'hA, 8'hA, 36'hA);
        rd(4'd3, rv); check("R8 unsuppressed counts", rv, 32'h00030001);

        rd(4'd15, rv); check("R10 undecoded reads zero", rv, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule